// File: doc/BRIEF.md
# Subcarrier-Locked Burst Gate Generator with Line Standard Detection

This block times the colour burst window for an analog video encoder, working entirely in the digital domain. It runs from a clock at four times the colour subcarrier and derives from it a one-in-four enable that marks each subcarrier period. An asynchronous, active-low composite sync is synchronised and then sampled once per subcarrier period. Each falling sync edge that is accepted restarts a saturating 9-bit line counter that counts subcarrier periods.

The block works out the line standard by itself. When a sync edge is accepted, the counter still holds the length of the line that just ended, and the bit worth 256 counts tells the two standards apart. A line of about 227.5 periods leaves that bit clear, so the standard is the 525-line NTSC one. A line of about 283.75 periods sets the bit, so the standard is the 625-line PAL one. The burst window then opens at a fixed count after the edge, and the standard sets both the count and the window length. Edges that come less than half a line after the last accepted edge, such as equalising pulses, are dropped.

An external flag can drive the gate directly in place of the internal window. A disable input forces the gate low. Each accepted line gives a one-clock pulse that downstream line-alternation logic can use.

Top module: `burst_gate_gen`

## Requirements
- R1: The sync input passes through two clock-domain flops and is then sampled once every four clocks. An accepted falling edge raises `lineAcc` for exactly one clock, 3 to 6 clocks after the falling edge of `syncInN`.
- R2: The first falling edge after reset is always accepted. After that, an edge is accepted only if at least 161 subcarrier periods (644 clocks) have passed since the last accepted edge. An ignored edge produces no `lineAcc` pulse and no burst window.
- R3: At an accepted edge, let L be the number of subcarrier periods since the previous accepted edge. `isPal` (1 = PAL, 0 = NTSC) becomes 1 if L-1 is at least 256 and 0 otherwise. The update happens in the same clock that `lineAcc` rises.
- R4: `isPal` keeps its value when the accepted edge is the first one after reset, and when L-1 is at least 511, because the counter has saturated.
- R5: In internal mode with `isPal`=0, `burstGate` rises 73 clocks after `lineAcc` rises and stays high for 36 clocks. This is 9 subcarrier periods, starting 18 periods after the edge.
- R6: In internal mode with `isPal`=1, `burstGate` rises 97 clocks after `lineAcc` rises and stays high for 40 clocks. This is 10 subcarrier periods, starting 24 periods after the edge.
- R7: The window of a line uses the standard decided at that same accepted edge, including on the line where the standard changes.
- R8: With `extSel`=1 and `burstOff`=0, `burstGate` equals `extFlagIn` delayed by one clock, and sync edges do not affect it.
- R9: With `burstOff`=1, `burstGate` is low from the next clock on, whatever the mode. Line acceptance and standard detection carry on unchanged.
- R10: During and after reset, `burstGate`, `isPal` and `lineAcc` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at four times the colour subcarrier |
| rstN | input | 1 | Asynchronous active-low reset |
| syncInN | input | 1 | Asynchronous composite sync, active low |
| extFlagIn | input | 1 | External burst flag, used when `extSel` is 1 |
| extSel | input | 1 | 1 selects the external flag as the gate source |
| burstOff | input | 1 | 1 forces the burst gate low |
| burstGate | output | 1 | Burst window, registered |
| isPal | output | 1 | Detected standard, 1 = PAL, 0 = NTSC |
| lineAcc | output | 1 | One-clock pulse per accepted sync edge |

## Verification
Two actions can fall on the same accepted edge: the standard decision and the start of that line's window. In one clock the edge must latch the new standard and restart the counter, and the window must then be timed with the new offset and length. This is provoked by moving from NTSC-length to PAL-length lines and back, by stepping across the 255/256/257 boundary, and by placing edges at exactly 160 and 161 periods. Each window is judged by its distance from `lineAcc` and by its width, which must match the standard the bench predicts arithmetically for that very edge.

// File: rtl/burst_gate_pkg.sv
package burst_gate_pkg;

  localparam int CNT_W       = 9;   // line counter width
  localparam int SC_DIV      = 4;   // clock cycles per subcarrier period
  localparam int SYNC_STAGES = 2;   // synchroniser depth
  localparam int HALF_LIM    = 160; // minimum count for an accepted edge
  localparam int STD_BIT     = 8;   // counter bit that separates standards
  localparam int NTSC_START  = 18;
  localparam int NTSC_LEN    = 9;
  localparam int PAL_START   = 24;
  localparam int PAL_LEN     = 10;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCnt;   // restart the line counter at this subcarrier tick
  } ctlStrobe_t;

endpackage

// File: rtl/sc_enable_gen.sv
module sc_enable_gen #(
  parameter int DIV = burst_gate_pkg::SC_DIV
) (
  input  logic clk,
  input  logic rstN,
  output logic scEn
);

  generate
    if (DIV <= 1) begin : g_direct
      assign scEn = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] phase;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                    phase <= phase + 1'b1;
      end

      assign scEn = (phase == LAST);
    end
  endgenerate

endmodule

// File: rtl/bg_datapath.sv
module bg_datapath
  import burst_gate_pkg::*;
#(
  parameter int CW     = CNT_W,
  parameter int STAGES = SYNC_STAGES
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          scEn,
  input  logic          syncInN,
  input  ctlStrobe_t    strobe,
  output logic          edgeSeen,
  output logic [CW-1:0] cnt
);

  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic [STAGES-1:0] syncPipe;
  logic              syncRes;
  logic              sampPrev;

  // metastability chain, reset to the idle (high) level
  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncPipe <= '1;
        else       syncPipe <= syncInN;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncPipe <= '1;
        else       syncPipe <= {syncPipe[STAGES-2:0], syncInN};
      end
    end
  endgenerate

  assign syncRes = syncPipe[STAGES-1];

  // sample once per subcarrier period
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     sampPrev <= 1'b1;
    else if (scEn) sampPrev <= syncRes;
  end

  assign edgeSeen = scEn & sampPrev & ~syncRes;

  // saturating line counter; starts saturated so the first edge is taken
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cnt <= CNT_MAX;
    else if (scEn) begin
      if (strobe.clrCnt)      cnt <= '0;
      else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/bg_control.sv
module bg_control
  import burst_gate_pkg::*;
#(
  parameter int CW      = CNT_W,
  parameter int HALF    = HALF_LIM,
  parameter int STDB    = STD_BIT,
  parameter int N_START = NTSC_START,
  parameter int N_LEN   = NTSC_LEN,
  parameter int P_START = PAL_START,
  parameter int P_LEN   = PAL_LEN
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          edgeSeen,
  input  logic [CW-1:0] cnt,
  input  logic          extFlagIn,
  input  logic          extSel,
  input  logic          burstOff,
  output ctlStrobe_t    strobe,
  output logic          burstGate,
  output logic          isPal,
  output logic          lineAcc
);

  localparam logic [CW-1:0] CNT_MAX  = {CW{1'b1}};
  localparam logic [CW-1:0] HALF_C   = CW'(HALF);
  localparam logic [CW-1:0] N_OPEN   = CW'(N_START);
  localparam logic [CW-1:0] N_CLOSE  = CW'(N_START + N_LEN);
  localparam logic [CW-1:0] P_OPEN   = CW'(P_START);
  localparam logic [CW-1:0] P_CLOSE  = CW'(P_START + P_LEN);

  logic          accept;
  logic          measured;
  logic [CW-1:0] winOpen;
  logic [CW-1:0] winClose;
  logic          winInt;
  logic          gateNext;

  // edges closer than half a line to the last accepted one are dropped
  assign accept   = edgeSeen && (cnt >= HALF_C);
  assign measured = (cnt != CNT_MAX);

  always_comb begin
    strobe        = '0;
    strobe.clrCnt = accept;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isPal   <= 1'b0;
      lineAcc <= 1'b0;
    end else begin
      lineAcc <= accept;
      if (accept && measured) isPal <= cnt[STDB];
    end
  end

  assign winOpen  = isPal ? P_OPEN  : N_OPEN;
  assign winClose = isPal ? P_CLOSE : N_CLOSE;
  assign winInt   = (cnt >= winOpen) && (cnt < winClose);

  always_comb begin
    if (burstOff)    gateNext = 1'b0;
    else if (extSel) gateNext = extFlagIn;
    else             gateNext = winInt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) burstGate <= 1'b0;
    else       burstGate <= gateNext;
  end

endmodule

// File: rtl/burst_gate_gen.sv
module burst_gate_gen
  import burst_gate_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic syncInN,
  input  logic extFlagIn,
  input  logic extSel,
  input  logic burstOff,
  output logic burstGate,
  output logic isPal,
  output logic lineAcc
);

  logic             scEn;
  logic             edgeSeen;
  logic [CNT_W-1:0] cnt;
  ctlStrobe_t       strobe;

  sc_enable_gen #(.DIV(SC_DIV)) u_scen (
    .clk  (clk),
    .rstN (rstN),
    .scEn (scEn)
  );

  bg_datapath #(.CW(CNT_W), .STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .scEn     (scEn),
    .syncInN  (syncInN),
    .strobe   (strobe),
    .edgeSeen (edgeSeen),
    .cnt      (cnt)
  );

  bg_control #(
    .CW(CNT_W), .HALF(HALF_LIM), .STDB(STD_BIT),
    .N_START(NTSC_START), .N_LEN(NTSC_LEN),
    .P_START(PAL_START), .P_LEN(PAL_LEN)
  ) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .edgeSeen  (edgeSeen),
    .cnt       (cnt),
    .extFlagIn (extFlagIn),
    .extSel    (extSel),
    .burstOff  (burstOff),
    .strobe    (strobe),
    .burstGate (burstGate),
    .isPal     (isPal),
    .lineAcc   (lineAcc)
  );

endmodule

// File: rtl/burst_gate_chk.sv
module burst_gate_chk (
  input logic clk,
  input logic rstN,
  input logic syncInN,
  input logic extFlagIn,
  input logic extSel,
  input logic burstOff,
  input logic burstGate,
  input logic isPal,
  input logic lineAcc
);

  AST_ACC_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    lineAcc |-> ($past(syncInN, 3) == 1'b0)); // R1

  AST_ACC_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    lineAcc |=> !lineAcc); // R1

  AST_STD_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(isPal) |-> lineAcc); // R3

  AST_EXT_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    $past(extSel && !burstOff) |-> (burstGate == $past(extFlagIn))); // R8

  AST_OFF_FORCES_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $past(burstOff) |-> !burstGate); // R9

  always_comb begin
    if (!rstN) begin
      AST_RESET_QUIET: assert (!burstGate && !isPal && !lineAcc); // R10
    end
  end

endmodule

bind burst_gate_gen burst_gate_chk u_chk (.*);

// File: tb/burst_gate_gen_tb.sv
module burst_gate_gen_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic syncInN = 1'b1;
  logic extFlagIn = 1'b0;
  logic extSel = 1'b0;
  logic burstOff = 1'b0;
  logic burstGate, isPal, lineAcc;

  burst_gate_gen u_dut (
    .clk(clk), .rstN(rstN), .syncInN(syncInN), .extFlagIn(extFlagIn),
    .extSel(extSel), .burstOff(burstOff),
    .burstGate(burstGate), .isPal(isPal), .lineAcc(lineAcc)
  );

  always #5 clk = ~clk;

  int  cyc = 0;
  int  nChecks = 0;
  int  nErr = 0;
  bit  expPal = 1'b0;
  bit  firstEdge = 1'b1;
  int  lastFall = 0;
  bit  accSeen = 1'b0;
  int  accCyc = 0;
  int  riseCyc = 0;
  bit  winChk = 1'b0;
  bit  offChk = 1'b0;
  bit  winPal = 1'b0;
  bit  lastWinPal = 1'b0;
  int  winCount = 0;
  int  winExp = 0;
  int  offRise = 0;
  bit  prevAcc = 1'b0;
  bit  prevGate = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // output monitor, sampled at the falling clock edge
  always @(negedge clk) begin
    if (rstN) begin
      if (lineAcc && !prevAcc) begin
        accSeen = 1'b1;
        accCyc  = cyc;
      end
      if (burstGate && !prevGate) begin
        riseCyc = cyc;
        if (offChk) offRise++;
      end
      if (!burstGate && prevGate && winChk) begin
        string tag;
        tag = (winPal != lastWinPal) ? "R7" : (winPal ? "R6" : "R5");
        chk((riseCyc - accCyc) == (winPal ? 97 : 73), tag,
            riseCyc - accCyc, winPal ? 97 : 73);
        chk((cyc - riseCyc) == (winPal ? 40 : 36), tag,
            cyc - riseCyc, winPal ? 40 : 36);
        lastWinPal = winPal;
        winCount++;
      end
      prevAcc  = lineAcc;
      prevGate = burstGate;
    end
  end

  // one sync falling edge, low for lowClk clocks, next fall gapClk clocks later
  task automatic line(input int gapClk, input int lowClk, input string tag);
    int  fallCyc;
    int  len;
    bit  acc;
    bit  upd;
    syncInN = 1'b0;
    fallCyc = cyc;
    accSeen = 1'b0;
    len     = 0;
    if (firstEdge) begin
      acc = 1'b1;
      upd = 1'b0;
    end else begin
      len = (fallCyc - lastFall) / 4;
      acc = (len - 1) >= 160;
      upd = acc && ((len - 1) < 511);
    end
    if (acc) begin
      firstEdge = 1'b0;
      lastFall  = fallCyc;
      if (upd) expPal = (len - 1) >= 256;
      if (winChk) winExp++;
      winPal = expPal;
    end
    repeat (8) @(negedge clk);
    chk(accSeen == acc, acc ? tag : "R2", accSeen, acc);
    if (acc && accSeen)
      chk((accCyc - fallCyc) >= 3 && (accCyc - fallCyc) <= 6, "R1",
          accCyc - fallCyc, 3);
    chk(isPal == expPal, upd ? "R3" : "R4", isPal, expPal);
    repeat (lowClk - 8) @(negedge clk);
    syncInN = 1'b1;
    repeat (gapClk - lowClk) @(negedge clk);
  endtask

  initial begin
    int sweep[14] = '{227, 228, 227, 228, 283, 284, 283, 284, 256, 255, 257, 256, 300, 227};

    repeat (5) @(negedge clk);
    chk(burstGate == 1'b0, "R10", burstGate, 0);
    chk(isPal == 1'b0, "R10", isPal, 0);
    chk(lineAcc == 1'b0, "R10", lineAcc, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(burstGate == 1'b0 && isPal == 1'b0 && lineAcc == 1'b0, "R10",
        {burstGate, isPal, lineAcc}, 0);

    // sweep of line lengths around both standards and the decision bit
    winChk = 1'b1;
    foreach (sweep[i]) line(sweep[i] * 4, 68, "R3");

    // equalising pulses at half-line spacing, NTSC then PAL
    line(456, 68, "R2");
    line(452, 12, "R2");
    line(1136, 68, "R2");
    line(568, 68, "R2");
    line(568, 12, "R2");
    line(1136, 68, "R2");

    // half-line boundary: 160 periods dropped, 161 taken
    line(640, 20, "R2");
    line(400, 20, "R2");
    line(644, 20, "R2");
    line(908, 20, "R2");

    // saturated counter leaves the standard alone
    line(908, 68, "R3");
    line(2200, 68, "R4");
    line(1136, 68, "R4");
    line(908, 68, "R3");
    line(1136, 68, "R3");

    // disable: gate quiet, detection continues
    winChk = 1'b0;
    burstOff = 1'b1;
    offChk = 1'b1;
    line(1136, 68, "R9");
    line(908, 68, "R9");
    line(908, 68, "R9");
    chk(offRise == 0, "R9", offRise, 0);
    chk(isPal == 1'b0, "R9", isPal, 0);
    burstOff = 1'b0;
    offChk = 1'b0;
    winChk = 1'b1;
    line(908, 68, "R3");
    line(1136, 68, "R3");

    // external flag mode
    winChk = 1'b0;
    extSel = 1'b1;
    for (int i = 0; i < 24; i++) begin
      bit v;
      v = ((i * 7) % 5) > 1;
      extFlagIn = v;
      @(negedge clk);
      chk(burstGate == v, "R8", burstGate, v);
    end
    extFlagIn = 1'b1;
    @(negedge clk);
    burstOff = 1'b1;
    @(negedge clk);
    chk(burstGate == 1'b0, "R9", burstGate, 0);
    burstOff = 1'b0;
    @(negedge clk);
    chk(burstGate == 1'b1, "R8", burstGate, 1);
    extFlagIn = 1'b0;
    extSel = 1'b0;
    repeat (2100) @(negedge clk);
    winChk = 1'b1;
    line(908, 68, "R4");
    line(1136, 68, "R3");

    chk(winCount == winExp, "R5", winCount, winExp);
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nErr++;
    $display("FAIL watchdog R1 actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule